// File: doc/BRIEF.md
# Reset Sequencer with Internal/External Cause Detection

This block sequences the reset of a processor core from four causes: power-up, an external device pulling the shared open-drain reset line low, a watchdog timeout, and a missing-clock detection (honoured only while its enable input is high). It drives the core's reset, drives the shared line low while it is the one asserting reset, and, when the core is released, reports which boot vector to fetch and whether an outside device was holding the line.

After power-up the block keeps the line and the core in reset for a long stabilization window. For an internal cause it pulls the line low for a short fixed window, lets go, and looks at the line again a fixed number of cycles later. A line that is still low at that moment is being held from outside. The cause is then treated as external and the core stays in reset until the line rises. When the core leaves reset, a two-bit vector code is presented for one cycle, and the three condition-code mask bits are forced to one.

Top module: `rst_source_ctrl`

## Requirements
- R1: After `rst` (synchronous, active high) falls, `core_rst` and `rst_pin_drive` stay high for exactly STAB_CYC (default 4064) cycles. The line is then released and treated as in R5, so that `vec_valid` first goes high in the STAB_CYC+2 nd cycle after `rst` falls.
- R2: While idle, the line read low at five consecutive clock edges starts a reset sequence. Four or fewer consecutive low edges start nothing, and `core_rst` and `rst_pin_drive` stay low.
- R3: A one-cycle `wdog_timeout` pulse, or a rising edge of (`clk_missing` AND `clkmon_en`), starts a sequence. `rst_pin_drive` goes high in the cycle after the request and stays high for exactly DRV_CYC (default 4) cycles. A `clk_missing` level that simply stays high makes no further requests.
- R4: While `clkmon_en` is low, `clk_missing` has no effect: `core_rst` stays low.
- R5: The line is sampled SAMP_DLY (default 2) cycles after release. If it reads high, `ext_source` becomes 0 and `core_rst` falls at that same edge. `core_rst` therefore stays high for exactly SAMP_DLY cycles after `rst_pin_drive` falls.
- R6: If the sample reads low, `ext_source` becomes 1 and `core_rst` stays high until the first edge at which the line reads high. `core_rst` falls at that edge.
- R7: The `vec_sel` code is 2'b00 if the sequence came from power-up, from the line (R2), or sampled low (R6). Otherwise it is 2'b01 if a missing-clock request was seen, and otherwise 2'b10 for a watchdog. Missing-clock outranks watchdog.
- R8: `vec_valid` is high for exactly one cycle, the first cycle in which `core_rst` is low. `vec_sel` and `ext_source` are valid in that cycle.
- R9: `sxi_force` is 3'b111 whenever `core_rst` or `vec_valid` is high, and 3'b000 otherwise.
- R10: A watchdog or missing-clock request during the drive, post-release or hold phase restarts the DRV_CYC drive window. During the power-up window it is recorded but neither extends nor shortens that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-up reset, synchronous, active high |
| rst_pin_in | input | 1 | Level read back from the shared reset line (1 = high) |
| wdog_timeout | input | 1 | Watchdog expiry pulse |
| clk_missing | input | 1 | Clock-missing indication from the analog monitor |
| clkmon_en | input | 1 | Enables the clock-missing cause |
| rst_pin_drive | output | 1 | Open-drain pull-down enable for the shared reset line |
| core_rst | output | 1 | Holds the core in reset |
| vec_valid | output | 1 | One-cycle strobe at reset exit |
| vec_sel | output | 2 | Boot vector code (00 power/external, 01 clock missing, 10 watchdog) |
| ext_source | output | 1 | 1 when the last sequence found the line held from outside |
| sxi_force | output | 3 | Forces the S, X and I mask bits to one |

## Verification
The bench drives the open-drain line from a model that combines the block's own pull-down with an external holder. This lets the same watchdog request come out either internal or external, depending only on whether the holder is still active at the sample edge. External pulses of four and of many cycles separate the filter's threshold from its trigger. Missing-clock requests with the enable low, a level held high, and one coinciding with a watchdog pulse separate the gating, the edge detection and the vector priority. Back-to-back watchdog pulses and a pulse during power-up stabilization separate a restart of the drive window from a request that is only recorded.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_STAB  = 3'd1,
        PH_DRIVE = 3'd2,
        PH_RELW  = 3'd3,
        PH_HOLD  = 3'd4
    } rsc_phase_e;

    typedef enum logic [1:0] {
        VEC_PWR_EXT = 2'b00,
        VEC_CLKMON  = 2'b01,
        VEC_WDOG    = 2'b10
    } rsc_vec_e;

    typedef struct packed {
        logic por;
        logic pin;
        logic clkmon;
        logic wdog;
    } rsc_cause_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Fixed priority: power/external, then clock monitor, then watchdog.
    function automatic rsc_vec_e pick_vec(input rsc_cause_t c, input logic held_low);
        if (c.por || c.pin || held_low) return VEC_PWR_EXT;
        if (c.clkmon)                   return VEC_CLKMON;
        if (c.wdog)                     return VEC_WDOG;
        return VEC_PWR_EXT;
    endfunction

endpackage

// File: rtl/rsc_req_detect.sv
module rsc_req_detect #(
    parameter int EXT_MIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic pin_in,
    input  logic wdog_timeout,
    input  logic clk_missing,
    input  logic clkmon_en,
    output logic ext_req,
    output logic wdog_req,
    output logic cm_req
);
    localparam int RUN_W = $clog2(EXT_MIN + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(EXT_MIN);

    logic [RUN_W-1:0] low_run;
    logic             cm_prev;
    logic             cm_lvl;

    // Consecutive low samples of the line while no sequence runs.
    always_ff @(posedge clk) begin
        if (rst || !idle || pin_in) begin
            low_run <= '0;
        end else if (low_run != RUN_FULL) begin
            low_run <= low_run + 1'b1;
        end
    end

    assign cm_lvl = clk_missing & clkmon_en;

    always_ff @(posedge clk) begin
        if (rst) cm_prev <= 1'b0;
        else     cm_prev <= cm_lvl;
    end

    assign ext_req  = idle && !pin_in && (low_run == RUN_FULL);
    assign cm_req   = cm_lvl && !cm_prev;
    assign wdog_req = wdog_timeout;

    AST_EXT_PRIOR_LOW: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> $past(!pin_in)); // R2

endmodule

// File: rtl/rsc_sequencer.sv
module rsc_sequencer
    import rsc_pkg::*;
#(
    parameter int STAB_CYC = 4064,
    parameter int DRV_CYC  = 4,
    parameter int SAMP_DLY = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    input  logic       ext_req,
    input  logic       wdog_req,
    input  logic       cm_req,
    output logic       idle,
    output logic       drive_low,
    output logic       held,
    output logic       vec_valid,
    output logic [1:0] vec_sel,
    output logic       ext_source
);
    localparam int CNT_MAX = max3(STAB_CYC, DRV_CYC, SAMP_DLY);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] STAB_LAST = CNT_W'(STAB_CYC - 1);
    localparam logic [CNT_W-1:0] DRV_LAST  = CNT_W'(DRV_CYC - 1);
    localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMP_DLY - 1);

    rsc_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    rsc_cause_t       cause;
    logic             samp_low;
    logic             fetch_q;
    rsc_vec_e         vec_q;
    logic             ext_q;
    logic             int_req;

    assign int_req = wdog_req | cm_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_STAB;
            cnt      <= '0;
            cause    <= '{por: 1'b1, pin: 1'b0, clkmon: 1'b0, wdog: 1'b0};
            samp_low <= 1'b0;
            fetch_q  <= 1'b0;
            vec_q    <= VEC_PWR_EXT;
            ext_q    <= 1'b0;
        end else begin
            fetch_q <= 1'b0;
            if (wdog_req) cause.wdog   <= 1'b1;
            if (cm_req)   cause.clkmon <= 1'b1;

            unique case (phase)
                PH_IDLE: begin
                    if (ext_req || int_req) begin
                        if (ext_req) cause.pin <= 1'b1;
                        phase    <= PH_DRIVE;
                        cnt      <= '0;
                        samp_low <= 1'b0;
                    end
                end
                PH_STAB: begin
                    if (cnt == STAB_LAST) begin
                        phase <= PH_RELW;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DRIVE, PH_RELW, PH_HOLD: begin
                    if (int_req) begin
                        phase    <= PH_DRIVE;
                        cnt      <= '0;
                        samp_low <= 1'b0;
                    end else if (phase == PH_DRIVE) begin
                        if (cnt == DRV_LAST) begin
                            phase <= PH_RELW;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else if (phase == PH_RELW) begin
                        if (cnt == SAMP_LAST) begin
                            if (!pin_in) begin
                                phase    <= PH_HOLD;
                                samp_low <= 1'b1;
                            end else begin
                                phase   <= PH_IDLE;
                                fetch_q <= 1'b1;
                                vec_q   <= pick_vec(cause, 1'b0);
                                ext_q   <= 1'b0;
                                cause   <= '0;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else if (pin_in) begin
                        phase   <= PH_IDLE;
                        fetch_q <= 1'b1;
                        vec_q   <= pick_vec(cause, samp_low);
                        ext_q   <= samp_low;
                        cause   <= '0;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign idle       = (phase == PH_IDLE);
    assign drive_low  = (phase == PH_STAB) || (phase == PH_DRIVE);
    assign held       = !idle;
    assign vec_valid  = fetch_q;
    assign vec_sel    = vec_q;
    assign ext_source = ext_q;

    AST_DRV_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DRIVE) |-> (cnt <= DRV_LAST)); // R3

    AST_EXT_VEC: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && ext_source) |-> (vec_sel == VEC_PWR_EXT)); // R7

endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
    import rsc_pkg::*;
#(
    parameter int STAB_CYC = 4064,
    parameter int DRV_CYC  = 4,
    parameter int SAMP_DLY = 2,
    parameter int EXT_MIN  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_pin_in,
    input  logic       wdog_timeout,
    input  logic       clk_missing,
    input  logic       clkmon_en,
    output logic       rst_pin_drive,
    output logic       core_rst,
    output logic       vec_valid,
    output logic [1:0] vec_sel,
    output logic       ext_source,
    output logic [2:0] sxi_force
);
    logic idle;
    logic ext_req;
    logic wdog_req;
    logic cm_req;

    rsc_req_detect #(
        .EXT_MIN (EXT_MIN)
    ) u_det (
        .clk          (clk),
        .rst          (rst),
        .idle         (idle),
        .pin_in       (rst_pin_in),
        .wdog_timeout (wdog_timeout),
        .clk_missing  (clk_missing),
        .clkmon_en    (clkmon_en),
        .ext_req      (ext_req),
        .wdog_req     (wdog_req),
        .cm_req       (cm_req)
    );

    rsc_sequencer #(
        .STAB_CYC (STAB_CYC),
        .DRV_CYC  (DRV_CYC),
        .SAMP_DLY (SAMP_DLY)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (rst_pin_in),
        .ext_req    (ext_req),
        .wdog_req   (wdog_req),
        .cm_req     (cm_req),
        .idle       (idle),
        .drive_low  (rst_pin_drive),
        .held       (core_rst),
        .vec_valid  (vec_valid),
        .vec_sel    (vec_sel),
        .ext_source (ext_source)
    );

    assign sxi_force = {3{core_rst | vec_valid}};

    AST_VEC_AT_EXIT: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (!core_rst && $past(core_rst))); // R8

    AST_DRIVE_HELD: assert property (@(posedge clk) disable iff (rst)
        rst_pin_drive |-> core_rst); // R3

endmodule

// File: tb/sim_rst_source_ctrl.sv
module sim_rst_source_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int STAB = 4064;
    localparam int DRV  = 4;
    localparam int SAMP = 2;
    localparam int EMIN = 4;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_low = 1'b0;
    logic wdog_timeout = 1'b0;
    logic clk_missing = 1'b0;
    logic clkmon_en = 1'b0;
    logic rst_pin_drive, core_rst, vec_valid, ext_source;
    logic [1:0] vec_sel;
    logic [2:0] sxi_force;
    logic pin_lvl;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pin_lvl = !(rst_pin_drive || ext_low);

    rst_source_ctrl u0 (
        .clk           (clk),
        .rst           (rst),
        .rst_pin_in    (pin_lvl),
        .wdog_timeout  (wdog_timeout),
        .clk_missing   (clk_missing),
        .clkmon_en     (clkmon_en),
        .rst_pin_drive (rst_pin_drive),
        .core_rst      (core_rst),
        .vec_valid     (vec_valid),
        .vec_sel       (vec_sel),
        .ext_source    (ext_source),
        .sxi_force     (sxi_force)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 power-up, 2 drive, 3 post-release, 4 hold.
    int  m_ph = 1, m_left = 0, m_run = 0;
    bit  m_por, m_pinf, m_cmf, m_copf, m_samp, m_cmprev;
    bit  m_vv, m_ext, armed;
    int  m_vs;

    function automatic void m_exit(input bit low);
        m_ph  = 0;
        m_vv  = 1;
        m_ext = low;
        if (m_por || m_pinf || low) m_vs = 0;
        else if (m_cmf)             m_vs = 1;
        else if (m_copf)            m_vs = 2;
        else                        m_vs = 0;
        m_por = 0; m_pinf = 0; m_cmf = 0; m_copf = 0;
    endfunction

    function automatic void m_start();
        m_ph = 2; m_left = DRV; m_samp = 0; m_run = 0;
    endfunction

    always @(posedge clk) begin
        bit drv_now, lvl, cml, cmr, req;
        drv_now = (m_ph == 1) || (m_ph == 2);
        lvl = !(drv_now || ext_low);
        cml = clk_missing && clkmon_en;
        cmr = cml && !m_cmprev;
        m_vv = 0;
        if (rst) begin
            armed = 1; m_ph = 1; m_left = STAB; m_por = 1;
            m_pinf = 0; m_cmf = 0; m_copf = 0; m_samp = 0;
            m_run = 0; m_vs = 0; m_ext = 0; m_cmprev = 0;
        end else begin
            m_cmprev = cml;
            req = wdog_timeout || cmr;
            if (wdog_timeout) m_copf = 1;
            if (cmr) m_cmf = 1;
            if (m_ph == 0) begin
                m_run = lvl ? 0 : m_run + 1;
                if (m_run > EMIN) begin
                    m_pinf = 1;
                    m_start();
                end else if (req) begin
                    m_start();
                end
            end else if (m_ph == 1) begin
                m_left--;
                if (m_left == 0) begin m_ph = 3; m_left = SAMP; end
            end else if (req) begin
                m_start();
            end else if (m_ph == 2) begin
                m_left--;
                if (m_left == 0) begin m_ph = 3; m_left = SAMP; end
            end else if (m_ph == 3) begin
                m_left--;
                if (m_left == 0) begin
                    if (!lvl) begin m_ph = 4; m_samp = 1; end
                    else m_exit(0);
                end
            end else if (lvl) begin
                m_exit(m_samp);
            end
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            chk("R3", "rst_pin_drive", int'(rst_pin_drive), int'(m_ph == 1 || m_ph == 2));
            chk("R1", "core_rst", int'(core_rst), int'(m_ph != 0));
            chk("R8", "vec_valid", int'(vec_valid), int'(m_vv));
            chk("R6", "ext_source", int'(ext_source), int'(m_ext));
            chk("R9", "sxi_force", int'(sxi_force), (m_ph != 0 || m_vv) ? 7 : 0);
            if (m_vv) chk("R7", "vec_sel", int'(vec_sel), m_vs);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!vec_valid && n < 20000);
    endtask

    initial begin
        int n;
        tick(3);
        chk("R1", "reset core_rst", int'(core_rst), 1);
        chk("R3", "reset pin drive", int'(rst_pin_drive), 1);
        chk("R8", "reset vec_valid", int'(vec_valid), 0);
        rst = 1'b0;
        wait_valid(n);
        chk("R1", "power-up exit cycle", n, STAB + SAMP);
        chk("R7", "power-up vector", int'(vec_sel), 0);
        chk("R5", "power-up internal", int'(ext_source), 0);
        tick(3);

        // Watchdog pulse: internal, vector 10.
        wdog_timeout = 1'b1; @(negedge clk); wdog_timeout = 1'b0;
        wait_valid(n);
        chk("R3", "watchdog exit cycle", n + 1, DRV + SAMP + 1);
        chk("R7", "watchdog vector", int'(vec_sel), 2);
        chk("R5", "watchdog internal", int'(ext_source), 0);
        tick(3);

        // Clock missing, monitor disabled.
        clkmon_en = 1'b0; clk_missing = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R4", "gated clock missing", int'(core_rst), 0);
        end
        clk_missing = 1'b0; tick(2);

        // Clock missing, monitor enabled; level stays high afterwards.
        clkmon_en = 1'b1; clk_missing = 1'b1; @(negedge clk);
        wait_valid(n);
        chk("R3", "clock-missing exit cycle", n + 1, DRV + SAMP + 1);
        chk("R7", "clock-missing vector", int'(vec_sel), 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R3", "held level no re-request", int'(core_rst), 0);
        end
        clk_missing = 1'b0; tick(2);

        // Both causes together: clock monitor wins.
        wdog_timeout = 1'b1; clk_missing = 1'b1; @(negedge clk); wdog_timeout = 1'b0;
        wait_valid(n);
        chk("R7", "both causes vector", int'(vec_sel), 1);
        clk_missing = 1'b0; tick(2);

        // External low for four edges: ignored.
        ext_low = 1'b1; tick(EMIN); ext_low = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2", "short low core_rst", int'(core_rst), 0);
            chk("R2", "short low drive", int'(rst_pin_drive), 0);
        end

        // External low held long: external, held until release.
        ext_low = 1'b1; tick(15);
        chk("R6", "held while line low", int'(core_rst), 1);
        ext_low = 1'b0;
        wait_valid(n);
        chk("R6", "release after line high", n, 1);
        chk("R6", "external flag", int'(ext_source), 1);
        chk("R7", "external vector", int'(vec_sel), 0);
        tick(3);

        // Second watchdog pulse restarts the drive window.
        wdog_timeout = 1'b1; @(negedge clk); wdog_timeout = 1'b0; @(negedge clk);
        wdog_timeout = 1'b1; @(negedge clk); wdog_timeout = 1'b0;
        wait_valid(n);
        chk("R10", "restart exit cycle", n + 3, 2 + DRV + SAMP + 1);
        chk("R7", "restart vector", int'(vec_sel), 2);
        tick(3);

        // Watchdog while an outside holder keeps the line low at the sample.
        wdog_timeout = 1'b1; @(negedge clk); wdog_timeout = 1'b0;
        tick(3); ext_low = 1'b1; tick(4); ext_low = 1'b0;
        wait_valid(n);
        chk("R6", "sampled-low exit", n, 1);
        chk("R5", "sampled-low external flag", int'(ext_source), 1);
        chk("R7", "sampled-low vector", int'(vec_sel), 0);
        tick(3);

        // Request during power-up window: recorded, window unchanged.
        rst = 1'b1; tick(2); rst = 1'b0;
        tick(100);
        wdog_timeout = 1'b1; @(negedge clk); wdog_timeout = 1'b0;
        wait_valid(n);
        chk("R10", "power-up window unchanged", n + 101, STAB + SAMP);
        chk("R7", "power-up outranks watchdog", int'(vec_sel), 0);
        tick(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule